// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers event pulses from a power-management device and reports them to a host through a single active-low interrupt line. Events fall into five groups: low-battery/thermal, step-down regulator, LDO regulator, GPIO and on/off. Each group latches its events in a status register that clears when it is read. Every group except GPIO also has a mask register. A top-level status byte summarises the groups and carries three level sources (RTC, 32 kHz oscillator, non-volatile error) straight through. A top-level mask byte decides which top bits may drive the line.

The host uses a byte-wide register port with an 8-bit address and separate read and write strobes, each active for one cycle. Read data is registered: it appears on `bus_rdata` one cycle after the read strobe and holds until the next read. A read of a group status address clears the bits it returns. The service routine therefore reads the top status byte first, then reads only the groups it flags.

Top module: `irq_hub`

## Requirements
- R1: After reset the mask registers read top 0xFF (0x0D), low-battery 0x0F (0x0E), step-down 0xFF (0x0F), LDO low 0xFF (0x10), LDO high 0xFF (0x11) and on/off 0xFF (0x12). All status registers read 0 and `irq_n` is 1.
- R2: A one-cycle event pulse is latched into its group status bit, and the bit reads back at these positions:
  - low-battery group at 0x06: event inputs 2/1/0 appear at bits 3/2/1.
  - step-down group at 0x07: event inputs 4:0 appear at bits 7:3.
  - LDO group: event inputs 7:0 appear at 0x08 bits 7:0, and input 8 appears at 0x09 bit 0.
  - GPIO group at 0x0A: inputs 7:0 appear at bits 7:0.
  - on/off group at 0x0B: inputs 7:0 appear at bits 7:0.
- R3: A read of a group status address returns its latched bits and clears them. The two LDO addresses clear only their own byte.
- R4: An event that arrives in the same cycle as the clearing read of its register stays latched.
- R5: Top status (0x05) bits 6 (step-down), 5 (LDO) and 1 (on/off) are 1 when their group holds a latched bit whose mask bit is 0. Group mask bits line up with status bits, with LDO mask bits 8:0 covering LDO sources 8:0. Bit 4 is 1 when any GPIO status bit is latched.
- R6: Top bit 7 is 1 only when low-battery mask bit 0 is 0 and a latched low-battery bit (3:1) has its mask bit clear.
- R7: Top bits 3, 2 and 0 follow the inputs `lvl_rtc`, `lvl_osc` and `lvl_nver` without latching.
- R8: `irq_n` is 0 exactly when some top status bit is 1 and the matching top mask bit is 0.
- R9: Writes to the mask addresses update those registers; the low-battery mask keeps only bits 3:0. Writes to status addresses have no effect.
- R10: Reads of the top status or mask addresses change no state.
- R11: `bus_rdata` takes the addressed value one cycle after a read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; clears group status registers |
| bus_rdata | output | 8 | Registered read data |
| ev_lbt | input | 3 | Low-battery, thermal 1, thermal 2 event pulses |
| ev_sd | input | 5 | Step-down fault event pulses |
| ev_ldo | input | 9 | LDO fault event pulses |
| ev_gpio | input | 8 | GPIO event pulses |
| ev_onoff | input | 8 | On/off event pulses |
| lvl_rtc | input | 1 | RTC interrupt level |
| lvl_osc | input | 1 | 32 kHz oscillator interrupt level |
| lvl_nver | input | 1 | Non-volatile error level |
| irq_n | output | 1 | Active-low interrupt to host |

## Verification
The assertions assume that read and write strobes are never raised together. They also assume that event inputs are single-cycle pulses, so a pulse seen at one edge is expected to be latched at the next. The stimulus drives exactly one strobe per bus task, drops it at the following falling edge, and raises each event bit for one cycle only. The level inputs are changed only between bus operations, which keeps the top-status expectations stable while they are sampled.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int LBT_N  = 3;
    localparam int SD_N   = 5;
    localparam int LDO_N  = 9;
    localparam int GPIO_N = 8;
    localparam int ON_N   = 8;
    localparam int LDO_MW = 2 * DW;

    localparam logic [AW-1:0] A_TOP_ST   = 8'h05;
    localparam logic [AW-1:0] A_LBT_ST   = 8'h06;
    localparam logic [AW-1:0] A_SD_ST    = 8'h07;
    localparam logic [AW-1:0] A_LDO_STL  = 8'h08;
    localparam logic [AW-1:0] A_LDO_STH  = 8'h09;
    localparam logic [AW-1:0] A_GPIO_ST  = 8'h0A;
    localparam logic [AW-1:0] A_ON_ST    = 8'h0B;
    localparam logic [AW-1:0] A_TOP_MSK  = 8'h0D;
    localparam logic [AW-1:0] A_LBT_MSK  = 8'h0E;
    localparam logic [AW-1:0] A_SD_MSK   = 8'h0F;
    localparam logic [AW-1:0] A_LDO_MSKL = 8'h10;
    localparam logic [AW-1:0] A_LDO_MSKH = 8'h11;
    localparam logic [AW-1:0] A_ON_MSK   = 8'h12;

    typedef struct packed {
        logic [DW-1:0]     topmask;
        logic [3:0]        lbtmask;
        logic [DW-1:0]     sdmask;
        logic [LDO_MW-1:0] ldomask;
        logic [DW-1:0]     onmask;
        logic [DW-1:0]     rdata;
    } hub_state_t;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);
    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        // a fresh event wins over a clear in the same cycle
        stat_d = (stat_q & ~clr) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

    p_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((stat & $past(ev)) == $past(ev)));

    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr) && !(|(ev & clr))) |=> ((stat & $past(clr)) == '0));

    p_event_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev & clr)) |=> ((stat & $past(ev & clr)) == $past(ev & clr)));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [LBT_N-1:0]  ev_lbt,
    input  logic [SD_N-1:0]   ev_sd,
    input  logic [LDO_N-1:0]  ev_ldo,
    input  logic [GPIO_N-1:0] ev_gpio,
    input  logic [ON_N-1:0]   ev_onoff,
    input  logic              lvl_rtc,
    input  logic              lvl_osc,
    input  logic              lvl_nver,
    output logic              irq_n
);
    hub_state_t st_d, st_q;

    logic [LBT_N-1:0]  lbt_stat;
    logic [SD_N-1:0]   sd_stat;
    logic [LDO_N-1:0]  ldo_stat;
    logic [GPIO_N-1:0] gpio_stat;
    logic [ON_N-1:0]   on_stat;
    logic [DW-1:0]     top_stat;
    logic [DW-1:0]     rd_mux;

    // per-address clear strobes
    logic rd_lbt, rd_sd, rd_ldol, rd_ldoh, rd_gpio, rd_on;
    assign rd_lbt  = bus_rd && (bus_addr == A_LBT_ST);
    assign rd_sd   = bus_rd && (bus_addr == A_SD_ST);
    assign rd_ldol = bus_rd && (bus_addr == A_LDO_STL);
    assign rd_ldoh = bus_rd && (bus_addr == A_LDO_STH);
    assign rd_gpio = bus_rd && (bus_addr == A_GPIO_ST);
    assign rd_on   = bus_rd && (bus_addr == A_ON_ST);

    logic [LDO_N-1:0] ldo_clr;
    always_comb begin
        for (int i = 0; i < LDO_N; i++)
            ldo_clr[i] = (i < DW) ? rd_ldol : rd_ldoh;
    end

    irq_group #(.W(LBT_N))  u_lbt  (.clk(clk), .rst_n(rst_n), .ev(ev_lbt),
                                    .clr({LBT_N{rd_lbt}}), .stat(lbt_stat));
    irq_group #(.W(SD_N))   u_sd   (.clk(clk), .rst_n(rst_n), .ev(ev_sd),
                                    .clr({SD_N{rd_sd}}), .stat(sd_stat));
    irq_group #(.W(LDO_N))  u_ldo  (.clk(clk), .rst_n(rst_n), .ev(ev_ldo),
                                    .clr(ldo_clr), .stat(ldo_stat));
    irq_group #(.W(GPIO_N)) u_gpio (.clk(clk), .rst_n(rst_n), .ev(ev_gpio),
                                    .clr({GPIO_N{rd_gpio}}), .stat(gpio_stat));
    irq_group #(.W(ON_N))   u_on   (.clk(clk), .rst_n(rst_n), .ev(ev_onoff),
                                    .clr({ON_N{rd_on}}), .stat(on_stat));

    // top-level summary
    always_comb begin
        top_stat    = '0;
        top_stat[7] = (|(lbt_stat & ~st_q.lbtmask[3:1])) & ~st_q.lbtmask[0];
        top_stat[6] = |(sd_stat & ~st_q.sdmask[7:3]);
        top_stat[5] = |(ldo_stat & ~st_q.ldomask[LDO_N-1:0]);
        top_stat[4] = |gpio_stat;
        top_stat[3] = lvl_rtc;
        top_stat[2] = lvl_osc;
        top_stat[1] = |(on_stat & ~st_q.onmask);
        top_stat[0] = lvl_nver;
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_TOP_ST:   rd_mux = top_stat;
            A_LBT_ST:   rd_mux = {4'b0, lbt_stat, 1'b0};
            A_SD_ST:    rd_mux = {sd_stat, 3'b0};
            A_LDO_STL:  rd_mux = ldo_stat[DW-1:0];
            A_LDO_STH:  rd_mux = {{(2*DW-LDO_N){1'b0}}, ldo_stat[LDO_N-1:DW]};
            A_GPIO_ST:  rd_mux = gpio_stat;
            A_ON_ST:    rd_mux = on_stat;
            A_TOP_MSK:  rd_mux = st_q.topmask;
            A_LBT_MSK:  rd_mux = {4'b0, st_q.lbtmask};
            A_SD_MSK:   rd_mux = st_q.sdmask;
            A_LDO_MSKL: rd_mux = st_q.ldomask[DW-1:0];
            A_LDO_MSKH: rd_mux = st_q.ldomask[LDO_MW-1:DW];
            A_ON_MSK:   rd_mux = st_q.onmask;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                A_TOP_MSK:  st_d.topmask = bus_wdata;
                A_LBT_MSK:  st_d.lbtmask = bus_wdata[3:0];
                A_SD_MSK:   st_d.sdmask  = bus_wdata;
                A_LDO_MSKL: st_d.ldomask[DW-1:0] = bus_wdata;
                A_LDO_MSKH: st_d.ldomask[LDO_MW-1:DW] = bus_wdata;
                A_ON_MSK:   st_d.onmask  = bus_wdata;
                default: ;
            endcase
        end
        if (bus_rd) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.topmask <= '1;
            st_q.lbtmask <= '1;
            st_q.sdmask  <= '1;
            st_q.ldomask <= '1;
            st_q.onmask  <= '1;
            st_q.rdata   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq_n     = ~|(top_stat & ~st_q.topmask);

    p_lbt_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lbtmask[0] |-> !top_stat[7]);

    p_level_drives_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_rtc && !st_q.topmask[3]) |-> !irq_n);

    p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.topmask) |-> irq_n);

    p_read_no_mask_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> ($stable(st_q.topmask) && $stable(st_q.ldomask)
                                 && $stable(st_q.onmask) && $stable(st_q.sdmask)));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] ev_lbt = '0;
    logic [4:0] ev_sd = '0;
    logic [8:0] ev_ldo = '0;
    logic [7:0] ev_gpio = '0;
    logic [7:0] ev_onoff = '0;
    logic       lvl_rtc = 1'b0, lvl_osc = 1'b0, lvl_nver = 1'b0;
    logic       irq_n;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    irq_hub u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
                .ev_lbt(ev_lbt), .ev_sd(ev_sd), .ev_ldo(ev_ldo), .ev_gpio(ev_gpio),
                .ev_onoff(ev_onoff), .lvl_rtc(lvl_rtc), .lvl_osc(lvl_osc),
                .lvl_nver(lvl_nver), .irq_n(irq_n));

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [2:0] l, input logic [4:0] s, input logic [8:0] ld,
                         input logic [7:0] g, input logic [7:0] o);
        @(negedge clk);
        ev_lbt = l; ev_sd = s; ev_ldo = ld; ev_gpio = g; ev_onoff = o;
        @(negedge clk);
        ev_lbt = '0; ev_sd = '0; ev_ldo = '0; ev_gpio = '0; ev_onoff = '0;
    endtask

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_n", irq_n, 1);
        rd(8'h0D, d); check("R1 top mask", d, 8'hFF);
        rd(8'h0E, d); check("R1 lbt mask", d, 8'h0F);
        rd(8'h0F, d); check("R1 sd mask", d, 8'hFF);
        rd(8'h10, d); check("R1 ldo mask lo", d, 8'hFF);
        rd(8'h11, d); check("R1 ldo mask hi", d, 8'hFF);
        rd(8'h12, d); check("R1 onoff mask", d, 8'hFF);
        rd(8'h05, d); check("R1 top status", d, 8'h00);
        for (logic [7:0] a = 8'h06; a <= 8'h0B; a++) begin
            rd(a, d); check("R1 group status", d, 0);
        end

        // R2/R3 on/off sweep with R5/R8 summary and line
        for (int i = 0; i < 8; i++) begin
            wr(8'h12, ~(8'(1) << i));
            pulse(0, 0, 0, 0, 8'hFF);
            rd(8'h05, d); check("R5 onoff top bit", d, 8'h02);
            check("R8 line masked", irq_n, 1);
            wr(8'h0D, 8'hFD);
            check("R8 line asserted", irq_n, 0);
            rd(8'h0B, d); check("R3 onoff read", d, 8'hFF);
            rd(8'h0B, d); check("R3 onoff cleared", d, 0);
            check("R8 line released", irq_n, 1);
            wr(8'h0D, 8'hFF);
        end
        // R5 masked source keeps summary low
        wr(8'h12, 8'hFF);
        pulse(0, 0, 0, 0, 8'h10);
        rd(8'h05, d); check("R5 masked onoff", d, 0);
        rd(8'h0B, d); check("R2 onoff bit4", d, 8'h10);

        // R2/R3/R5 step-down sweep
        for (int i = 0; i < 5; i++) begin
            wr(8'h0F, ~(8'(1) << (i + 3)));
            pulse(0, 5'(1) << i, 0, 0, 0);
            rd(8'h05, d); check("R5 sd top bit", d, 8'h40);
            rd(8'h07, d); check("R2 sd position", d, 8'(1) << (i + 3));
            rd(8'h07, d); check("R3 sd cleared", d, 0);
        end
        wr(8'h0F, 8'hFF);

        // R2/R3 LDO sweep
        wr(8'h10, 8'h00); wr(8'h11, 8'h00);
        for (int i = 0; i < 9; i++) begin
            pulse(0, 0, 9'(1) << i, 0, 0);
            rd(8'h05, d); check("R5 ldo top bit", d, 8'h20);
            rd(8'h08, d); check("R2 ldo low", d, (i < 8) ? (1 << i) : 0);
            rd(8'h09, d); check("R2 ldo high", d, (i == 8) ? 1 : 0);
            rd(8'h05, d); check("R3 ldo summary cleared", d, 0);
        end
        // R3 halves clear separately
        pulse(0, 0, 9'h1FF, 0, 0);
        rd(8'h08, d); check("R3 ldo low half", d, 8'hFF);
        rd(8'h05, d); check("R3 ldo high remains", d, 8'h20);
        rd(8'h09, d); check("R3 ldo high half", d, 1);
        rd(8'h05, d); check("R3 ldo all clear", d, 0);

        // R2/R5 GPIO sweep, no group mask
        for (int i = 0; i < 8; i++) begin
            pulse(0, 0, 0, 8'(1) << i, 0);
            rd(8'h05, d); check("R5 gpio top bit", d, 8'h10);
            rd(8'h0A, d); check("R2 gpio position", d, 8'(1) << i);
            rd(8'h0A, d); check("R3 gpio cleared", d, 0);
        end

        // R2/R6 low-battery group and its enable bit
        for (int i = 0; i < 3; i++) begin
            wr(8'h0E, 8'h01);
            pulse(3'(1) << i, 0, 0, 0, 0);
            rd(8'h05, d); check("R6 group disabled", d, 0);
            wr(8'h0E, 8'h00);
            rd(8'h05, d); check("R6 group enabled", d, 8'h80);
            rd(8'h06, d); check("R2 lbt position", d, 8'(1) << (i + 1));
            rd(8'h06, d); check("R3 lbt cleared", d, 0);
        end
        wr(8'h0E, 8'hFF);
        rd(8'h0E, d); check("R9 lbt mask width", d, 8'h0F);

        // R4 event in the clearing cycle
        pulse(0, 0, 0, 0, 8'h04);
        @(negedge clk);
        bus_addr = 8'h0B; bus_rd = 1'b1; ev_onoff = 8'h20;
        @(negedge clk);
        bus_rd = 1'b0; ev_onoff = '0;
        check("R4 old value returned", bus_rdata, 8'h04);
        rd(8'h0B, d); check("R4 new event kept", d, 8'h20);

        // R7 level inputs
        lvl_rtc = 1'b1;
        rd(8'h05, d); check("R7 rtc", d, 8'h08);
        check("R8 rtc masked", irq_n, 1);
        wr(8'h0D, 8'hF7);
        check("R8 rtc unmasked", irq_n, 0);
        lvl_rtc = 1'b0; lvl_osc = 1'b1; lvl_nver = 1'b1;
        rd(8'h05, d); check("R7 osc nver", d, 8'h05);
        check("R8 other bits masked", irq_n, 1);
        rd(8'h05, d); check("R7 not latched", d, 8'h05);
        lvl_osc = 1'b0; lvl_nver = 1'b0;
        rd(8'h05, d); check("R7 follows level", d, 0);

        // R9 writes
        wr(8'h0F, 8'h5A); rd(8'h0F, d); check("R9 sd mask write", d, 8'h5A);
        wr(8'h11, 8'hA5); rd(8'h11, d); check("R9 ldo mask hi write", d, 8'hA5);
        pulse(0, 0, 0, 8'h01, 0);
        wr(8'h0A, 8'h00);
        rd(8'h0A, d); check("R9 status write ignored", d, 8'h01);
        wr(8'h0B, 8'hFF);
        rd(8'h0B, d); check("R9 onoff write ignored", d, 0);
        wr(8'h05, 8'hFF);
        rd(8'h05, d); check("R9 top write ignored", d, 0);

        // R10 non-destructive reads, R11 hold
        pulse(0, 0, 0, 0, 8'h80);
        wr(8'h12, 8'h7F);
        rd(8'h05, d); rd(8'h12, d); check("R10 mask unchanged", d, 8'h7F);
        rd(8'h05, d); check("R10 top read twice", d, 8'h02);
        repeat (3) @(negedge clk);
        check("R11 rdata held", bus_rdata, 8'h02);
        rd(8'h0B, d); check("R10 onoff still latched", d, 8'h80);

        report();
        $finish;
    end
endmodule